// File: doc/BRIEF.md
# Programmable Bit-Routing Output Stage

This block forms the output half of one instruction step in a stream bit-transformation engine. Every bit of a 32-bit result word picks exactly one bit out of a 192-bit pool of sources. The pool holds:

- the 64-bit input register;
- the result word of the previous executed step;
- both 16-bit counters;
- the current lookup-table entry;
- thirty comparison flags between counter B and the previous result;
- a constant 0 and a constant 1.

The previous result also supplies the address of the lookup table. The table itself sits outside the block. Its entry width is chosen by a mode input and is 32, 16 or 8 bits.

An instruction decoder in front of the block supplies one 8-bit source code per output bit and a write-size code. A step-enable input marks the cycles in which an instruction really executes. When it is low, the engine is stalled. On an executed step the routed word is captured as the new previous result. If the write size is not zero, an output-stream beat also appears one cycle later, carrying the low 8, 16 or 32 bits of that word.

Top module: `bitroute_stage`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the previous-result register is zero and `beat_valid_o` is low.
- R2: Output bit i takes the source addressed by its code `sel_i[8*i +: 8]`:
  - codes 0..63 select input-register bit (code);
  - codes 64..95 select previous-result bit (code-64);
  - codes 96..111 select counter A bit (code-96);
  - codes 112..127 select counter B bit (code-112).
- R3: Code 191 drives the bit to 1. Code 190 drives it to 0. Codes 192..255 are unrouted and also drive 0.
- R4: `lut_addr_o` is taken from the top bits of the previous result:
  - `lut_width_i` = 0 (32-bit entries) or 3 (treated as 32-bit): bits 31..23, upper address bits zero;
  - `lut_width_i` = 1 (16-bit entries): bits 31..22, upper address bit zero;
  - `lut_width_i` = 2 (8-bit entries): bits 31..21.
- R5: Codes 128..159 select bit (code-128) of the lookup source. For 16-bit and 8-bit modes the lookup source is `lut_data_i` with everything above the entry width forced to 0.
- R6: Codes 160..189 select comparison flag (code-160). Operator op is 0 for `<=`, 1 for `>` and 2 for `=`, applied as counter-B-part op previous-result-field. The flags are ordered as follows:
  - flag 3*k+op (k = 0, 1) compares the full counter B with previous bits [16k+15:16k];
  - flag 6+3*k+op (k = 0..3) compares B[15:8] with previous bits [8k+7:8k];
  - flag 18+3*k+op compares B[7:0] with the same byte.
- R7: `wr_size_i` is 0 for no write, 1 for 8 bits, 2 for 16 bits and 3 for 32 bits. After an executed step with a non-zero size, `beat_valid_o` is high for one cycle. `beat_size_o` then repeats the code and `beat_data_o` holds the low n bits of the routed word, with zeros above them.
- R8: The previous result loads the routed word on every executed step, including steps with write size 0. When `step_i` is low, the previous result holds its value and no beat is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction executes this cycle (low = stalled) |
| sel_i | input | 256 | 8-bit source code per output bit, bit i at [8i+7:8i] |
| wr_size_i | input | 2 | Write-size code |
| in_reg_i | input | 64 | Input register contents |
| ctr_a_i | input | 16 | Counter A |
| ctr_b_i | input | 16 | Counter B |
| lut_width_i | input | 2 | Lookup entry width mode |
| lut_addr_o | output | 11 | Lookup table entry index |
| lut_data_i | input | 32 | Entry read at `lut_addr_o`, entry in low bits |
| word_o | output | 32 | Routed word of the current instruction |
| beat_valid_o | output | 1 | Output-stream beat present |
| beat_size_o | output | 2 | Size code of the beat |
| beat_data_o | output | 32 | Beat payload, unused upper bits zero |

## Verification
The bench aims at the following corner cases, each paired with the failure it would expose:

- **Write-0 steps.** The bench loads the previous result with a step that writes nothing, then reads it back through previous-result codes. A design that only captured on real writes would return stale data.
- **Stalls.** The bench stalls with a non-zero write size. A stall that leaked would show up as an unexpected beat or a changed previous result.
- **Lookup widths.** All four width modes are driven while the external table returns a full 32-bit word. An address slice that is off by one, or narrow entries that are not zero-extended, would give wrong address or lookup bits.
- **Comparison flags.** All thirty flags are routed at once. The bench uses counter values that sit equal to, just above and just below each compared field. A swapped flag order or a wrong operator then shows as flipped bits.

// File: rtl/bitroute_pkg.sv
package bitroute_pkg;

  localparam int OUT_W  = 32;
  localparam int IN_W   = 64;
  localparam int CTR_W  = 16;
  localparam int SEL_W  = 8;
  localparam int NFLAG  = 30;
  localparam int ADDR_W = 11;

  // Source code map (start of each region)
  localparam int SRC_IN   = 0;
  localparam int SRC_PREV = SRC_IN + IN_W;
  localparam int SRC_A    = SRC_PREV + OUT_W;
  localparam int SRC_B    = SRC_A + CTR_W;
  localparam int SRC_LUT  = SRC_B + CTR_W;
  localparam int SRC_FLAG = SRC_LUT + OUT_W;
  localparam int SRC_ZERO = SRC_FLAG + NFLAG;
  localparam int SRC_ONE  = SRC_ZERO + 1;
  localparam int SRC_N    = SRC_ONE + 1;

  typedef enum logic [1:0] {WR_NONE = 2'd0, WR_8 = 2'd1, WR_16 = 2'd2, WR_32 = 2'd3} wr_size_e;
  typedef enum logic [1:0] {LW_32 = 2'd0, LW_16 = 2'd1, LW_8 = 2'd2, LW_32ALT = 2'd3} lut_width_e;

  // op: 0 => a <= b, 1 => a > b, 2 => a == b
  function automatic logic cmp_op(input logic [CTR_W-1:0] a, input logic [CTR_W-1:0] b,
                                  input int op);
    case (op)
      0:       return a <= b;
      1:       return a > b;
      default: return a == b;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] lut_index(input logic [OUT_W-1:0] prev,
                                                  input logic [1:0] width);
    case (width)
      LW_16:   return {1'b0, prev[OUT_W-1 -: 10]};
      LW_8:    return prev[OUT_W-1 -: 11];
      default: return {2'b00, prev[OUT_W-1 -: 9]};
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] lut_extend(input logic [OUT_W-1:0] data,
                                                  input logic [1:0] width);
    case (width)
      LW_16:   return {16'h0, data[15:0]};
      LW_8:    return {24'h0, data[7:0]};
      default: return data;
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] size_mask(input logic [1:0] size);
    case (size)
      WR_8:    return 32'h0000_00FF;
      WR_16:   return 32'h0000_FFFF;
      WR_32:   return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/bitroute_cmp.sv
module bitroute_cmp
  import bitroute_pkg::*;
#(
  parameter int W_OUT = OUT_W,
  parameter int W_CTR = CTR_W,
  parameter int N_FLG = NFLAG
) (
  input  logic [W_CTR-1:0] ctr_b,
  input  logic [W_OUT-1:0] prev,
  output logic [N_FLG-1:0] flags
);
  localparam int NOPS   = 3;
  localparam int NWIDE  = W_OUT / W_CTR;
  localparam int NBYTE  = W_OUT / 8;
  localparam int HI_OFS = NWIDE * NOPS;
  localparam int LO_OFS = HI_OFS + NBYTE * NOPS;

  for (genvar k = 0; k < NWIDE; k++) begin : g_wide
    for (genvar op = 0; op < NOPS; op++) begin : g_op
      assign flags[k*NOPS + op] = cmp_op(ctr_b, prev[k*W_CTR +: W_CTR], op);
    end
  end

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    for (genvar op = 0; op < NOPS; op++) begin : g_op
      assign flags[HI_OFS + k*NOPS + op] =
        cmp_op({8'h00, ctr_b[15:8]}, {8'h00, prev[k*8 +: 8]}, op);
      assign flags[LO_OFS + k*NOPS + op] =
        cmp_op({8'h00, ctr_b[7:0]}, {8'h00, prev[k*8 +: 8]}, op);
    end
  end
endmodule

// File: rtl/bitroute_lut_port.sv
module bitroute_lut_port
  import bitroute_pkg::*;
#(
  parameter int W_OUT  = OUT_W,
  parameter int W_ADDR = ADDR_W
) (
  input  logic [W_OUT-1:0]  prev,
  input  logic [1:0]        width,
  output logic [W_ADDR-1:0] addr,
  input  logic [W_OUT-1:0]  rdata,
  output logic [W_OUT-1:0]  lut_src
);
  always_comb begin
    addr    = lut_index(prev, width);
    lut_src = lut_extend(rdata, width);
  end
endmodule

// File: rtl/bitroute_xbar.sv
module bitroute_xbar
  import bitroute_pkg::*;
#(
  parameter int W_OUT = OUT_W,
  parameter int W_SEL = SEL_W,
  parameter int N_SRC = SRC_N
) (
  input  logic [N_SRC-1:0]       src,
  input  logic [W_OUT*W_SEL-1:0] sel,
  output logic [W_OUT-1:0]       word
);
  localparam int SPAN = 1 << W_SEL;

  logic [SPAN-1:0] src_pad;
  assign src_pad = {{(SPAN-N_SRC){1'b0}}, src};

  for (genvar i = 0; i < W_OUT; i++) begin : g_bit
    logic [W_SEL-1:0] code;
    assign code    = sel[i*W_SEL +: W_SEL];
    assign word[i] = src_pad[code];
  end
endmodule

// File: rtl/bitroute_beat.sv
module bitroute_beat
  import bitroute_pkg::*;
#(
  parameter int W_OUT = OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [1:0]       size,
  input  logic [W_OUT-1:0] word,
  output logic             valid,
  output logic [1:0]       size_q,
  output logic [W_OUT-1:0] data
);
  logic push;
  assign push = fire && (size != WR_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      size_q <= WR_NONE;
      data   <= '0;
    end else begin
      valid <= push;
      if (push) begin
        size_q <= size;
        data   <= word & size_mask(size);
      end
    end
  end
endmodule

// File: rtl/bitroute_stage.sv
module bitroute_stage
  import bitroute_pkg::*;
#(
  parameter int W_OUT  = OUT_W,
  parameter int W_IN   = IN_W,
  parameter int W_CTR  = CTR_W,
  parameter int W_SEL  = SEL_W,
  parameter int W_ADDR = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step_i,
  input  logic [W_OUT*W_SEL-1:0] sel_i,
  input  logic [1:0]             wr_size_i,
  input  logic [W_IN-1:0]        in_reg_i,
  input  logic [W_CTR-1:0]       ctr_a_i,
  input  logic [W_CTR-1:0]       ctr_b_i,
  input  logic [1:0]             lut_width_i,
  output logic [W_ADDR-1:0]      lut_addr_o,
  input  logic [W_OUT-1:0]       lut_data_i,
  output logic [W_OUT-1:0]       word_o,
  output logic                   beat_valid_o,
  output logic [1:0]             beat_size_o,
  output logic [W_OUT-1:0]       beat_data_o
);
  localparam int N_SRC = W_IN + W_OUT + 2*W_CTR + W_OUT + NFLAG + 2;

  logic [W_OUT-1:0] prev_q;
  logic [W_OUT-1:0] lut_src;
  logic [NFLAG-1:0] flags;
  logic [N_SRC-1:0] src_vec;
  logic [W_OUT-1:0] routed;

  bitroute_cmp #(.W_OUT(W_OUT), .W_CTR(W_CTR), .N_FLG(NFLAG)) u_cmp (
    .ctr_b (ctr_b_i),
    .prev  (prev_q),
    .flags (flags)
  );

  bitroute_lut_port #(.W_OUT(W_OUT), .W_ADDR(W_ADDR)) u_lut (
    .prev    (prev_q),
    .width   (lut_width_i),
    .addr    (lut_addr_o),
    .rdata   (lut_data_i),
    .lut_src (lut_src)
  );

  // LSB-first concatenation order matches the source code map
  assign src_vec = {1'b1, 1'b0, flags, lut_src, ctr_b_i, ctr_a_i, prev_q, in_reg_i};

  bitroute_xbar #(.W_OUT(W_OUT), .W_SEL(W_SEL), .N_SRC(N_SRC)) u_xbar (
    .src  (src_vec),
    .sel  (sel_i),
    .word (routed)
  );

  assign word_o = routed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= '0;
    else if (step_i) prev_q <= routed;
  end

  bitroute_beat #(.W_OUT(W_OUT)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (step_i),
    .size   (wr_size_i),
    .word   (routed),
    .valid  (beat_valid_o),
    .size_q (beat_size_o),
    .data   (beat_data_o)
  );
endmodule

// File: rtl/bitroute_stage_chk.sv
module bitroute_stage_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         step_i,
  input logic [255:0] sel_i,
  input logic [1:0]   wr_size_i,
  input logic [1:0]   lut_width_i,
  input logic [10:0]  lut_addr_o,
  input logic [31:0]  word_o,
  input logic         beat_valid_o,
  input logic [1:0]   beat_size_o,
  input logic [31:0]  beat_data_o,
  input logic [31:0]  prev_q
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !beat_valid_o);

  p_const_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i[7:0] == 8'd191 |-> word_o[0]);

  p_const_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i[7:0] >= 8'd190 && sel_i[7:0] != 8'd191 |-> !word_o[0]);

  p_lut_addr8_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lut_width_i == 2'd2 |-> lut_addr_o == prev_q[31:21]);

  p_beat_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o |-> $past(step_i) && $past(wr_size_i) != 2'd0);

  p_beat_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && beat_size_o == 2'd1 |-> beat_data_o[31:8] == 24'h0);

  p_beat_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && beat_size_o == 2'd2 |-> beat_data_o[31:16] == 16'h0);

  p_prev_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(prev_q));

  p_prev_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> prev_q == $past(word_o));
endmodule

bind bitroute_stage bitroute_stage_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_i       (step_i),
  .sel_i        (sel_i),
  .wr_size_i    (wr_size_i),
  .lut_width_i  (lut_width_i),
  .lut_addr_o   (lut_addr_o),
  .word_o       (word_o),
  .beat_valid_o (beat_valid_o),
  .beat_size_o  (beat_size_o),
  .beat_data_o  (beat_data_o),
  .prev_q       (prev_q)
);

// File: tb/bitroute_stage_tb.sv
module bitroute_stage_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         step_i = 0;
  logic [255:0] sel_i;
  logic [1:0]   wr_size_i = 0;
  logic [63:0]  in_reg_i = 0;
  logic [15:0]  ctr_a_i = 0;
  logic [15:0]  ctr_b_i = 0;
  logic [1:0]   lut_width_i = 0;
  logic [10:0]  lut_addr_o;
  logic [31:0]  lut_data_i;
  logic [31:0]  word_o;
  logic         beat_valid_o;
  logic [1:0]   beat_size_o;
  logic [31:0]  beat_data_o;

  bitroute_stage u_dut (.*);

  always #10 clk = ~clk;

  logic [7:0]  sel_m [32];
  logic [31:0] prev_m = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [33:0] sb_q[$];

  always_comb
    for (int i = 0; i < 32; i++) sel_i[i*8 +: 8] = sel_m[i];

  function automatic logic [31:0] tbl(input logic [10:0] a);
    return (32'h9E37_79B9 * ({21'h0, a} + 32'd1)) ^ 32'h5A00_C3F0;
  endfunction
  assign lut_data_i = tbl(lut_addr_o);

  function automatic logic [10:0] exp_addr();
    if (lut_width_i == 2'd1) return 11'(prev_m >> 22);
    if (lut_width_i == 2'd2) return 11'(prev_m >> 21);
    return 11'(prev_m >> 23);
  endfunction

  function automatic logic [31:0] exp_lut();
    logic [31:0] v = tbl(exp_addr());
    if (lut_width_i == 2'd1) return v % 32'h1_0000;
    if (lut_width_i == 2'd2) return v % 32'h100;
    return v;
  endfunction

  function automatic logic rel(input int x, input int y, input int op);
    if (op == 0) return x <= y;
    if (op == 1) return x > y;
    return x == y;
  endfunction

  function automatic logic flag_m(input int idx);
    int x, y;
    if (idx < 6) begin
      x = ctr_b_i;
      y = (prev_m >> (16 * (idx / 3))) & 32'hFFFF;
    end else if (idx < 18) begin
      x = ctr_b_i >> 8;
      y = (prev_m >> (8 * ((idx - 6) / 3))) & 32'hFF;
    end else begin
      x = ctr_b_i & 16'hFF;
      y = (prev_m >> (8 * ((idx - 18) / 3))) & 32'hFF;
    end
    return rel(x, y, idx % 3);
  endfunction

  function automatic logic src_bit(input int c);
    if (c < 64)  return in_reg_i[c];
    if (c < 96)  return prev_m[c-64];
    if (c < 112) return ctr_a_i[c-96];
    if (c < 128) return ctr_b_i[c-112];
    if (c < 160) return exp_lut() >> (c-128);
    if (c < 190) return flag_m(c-160);
    return c == 191;
  endfunction

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[i] = src_bit(int'(sel_m[i]));
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic fill(input int code);
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(code);
  endtask

  // One instruction: drive at negedge, check combinational results, clock it
  task automatic run(input logic stp, input logic [1:0] wr, input string tag);
    logic [31:0] e;
    logic [31:0] keep;
    @(negedge clk);
    step_i = stp; wr_size_i = wr;
    #1;
    e = model_word();
    chk(tag, word_o, e);
    chk({tag, " R4 addr"}, {21'h0, lut_addr_o}, {21'h0, exp_addr()});
    if (stp && wr != 0) begin
      keep = (wr == 2'd3) ? e : (wr == 2'd2) ? {16'h0, e[15:0]} : {24'h0, e[7:0]};
      sb_q.push_back({wr, keep});
    end
    @(posedge clk); #1;
    if (stp) prev_m = e;
    step_i = 0;
  endtask

  // Monitor: pops expected beats
  always @(negedge clk) begin
    if (rst_n && beat_valid_o) begin
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7/R8 beat: got unexpected %h size %0d expected none", beat_data_o, beat_size_o);
      end else begin
        logic [33:0] x;
        x = sb_q.pop_front();
        if ({beat_size_o, beat_data_o} !== x) begin
          n_bad++;
          $display("FAIL R7 beat: got %0d/%h expected %0d/%h", beat_size_o, beat_data_o, x[33:32], x[31:0]);
        end
      end
    end
  end

  task automatic load_prev(input logic [31:0] p);
    in_reg_i[31:0] = p;
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(i);
    run(1, 2'd0, "R8 load via write-0");
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    fill(190);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 beat_valid in reset", {31'h0, beat_valid_o}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 beat_valid after reset", {31'h0, beat_valid_o}, 32'h0);
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(64 + i);
    in_reg_i = 64'hFFFF_FFFF_FFFF_FFFF;
    run(0, 2'd0, "R1 previous result zero");

    // R2 nibble swap over several bytes, 8-bit writes
    for (int i = 0; i < 32; i++) sel_m[i] = 8'd190;
    for (int i = 0; i < 4; i++) begin sel_m[i] = 8'(i + 4); sel_m[i+4] = 8'(i); end
    foreach (sel_m[i]) ;
    in_reg_i = 64'h0123_4567_89AB_CD67; run(1, 2'd1, "R2 nibble swap 67");
    in_reg_i = 64'h0000_0000_0000_00A5; run(1, 2'd1, "R2 nibble swap A5");
    in_reg_i = 64'hFFFF_FFFF_FFFF_FF0F; run(1, 2'd1, "R2 nibble swap 0F");

    // R2 upper input half, 32-bit write
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(32 + i);
    in_reg_i = 64'hDEAD_BEEF_1234_5678; run(1, 2'd3, "R2 upper input R7 wr32");

    // R2 counters, 16-bit write
    for (int i = 0; i < 16; i++) begin sel_m[i] = 8'(96 + i); sel_m[i+16] = 8'(112 + i); end
    ctr_a_i = 16'hC0DE; ctr_b_i = 16'h1F2E; run(1, 2'd2, "R2 counters R7 wr16");

    // R8: write-0 step still updates; then read back reversed
    in_reg_i = 64'h0; in_reg_i[31:0] = 32'hA5C3_0F81;
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(i);
    run(1, 2'd0, "R8 write-0 step");
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(64 + 31 - i);
    run(1, 2'd1, "R8 prev readback reversed");
    // stall: different data, no beat, prev held
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(i);
    in_reg_i = 64'hFFFF_FFFF_0000_FFFF;
    run(0, 2'd3, "R8 stalled step");
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(64 + i);
    run(0, 2'd0, "R8 prev held after stall");

    // R3 constants and unused codes
    for (int i = 0; i < 32; i++) sel_m[i] = 8'(190 + (i % 8) * 9);
    sel_m[0] = 8'd191; sel_m[5] = 8'd255; sel_m[6] = 8'd192;
    run(1, 2'd3, "R3 constants and unused codes");

    // R4/R5 all width modes with several previous values
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 3; p++) begin
        lut_width_i = 2'(w);
        load_prev((p == 0) ? 32'hFFE0_0000 : (p == 1) ? 32'h8020_0000 : 32'h3A5F_0123);
        for (int i = 0; i < 32; i++) sel_m[i] = 8'(128 + i);
        run(0, 2'd0, $sformatf("R4 R5 lut width %0d prev %0d", w, p));
      end
    end
    lut_width_i = 0;

    // R6 comparison flags, bit 30/31 constants
    for (int t = 0; t < 5; t++) begin
      case (t)
        0: begin load_prev(32'h1234_5678); ctr_b_i = 16'h5678; end
        1: begin load_prev(32'h1234_5678); ctr_b_i = 16'h1234; end
        2: begin load_prev(32'h8000_7FFF); ctr_b_i = 16'h7FFF; end
        3: begin load_prev(32'h11FF_0022); ctr_b_i = 16'h1122; end
        default: begin load_prev(32'h0000_0000); ctr_b_i = 16'h0001; end
      endcase
      for (int i = 0; i < 30; i++) sel_m[i] = 8'(160 + i);
      sel_m[30] = 8'd191; sel_m[31] = 8'd190;
      run(1, 2'd3, $sformatf("R6 flags pattern %0d", t));
    end

    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule